// File: doc/BRIEF.md
# Telemetry Downlink Bit Encoder Chain

This block turns a serial stream of telemetry frame bits into the channel symbol stream that feeds a transmitter. Each accepted data bit goes through four line-coding steps in a fixed sequence. First it is whitened by a frame-synchronous pseudo-random sequence. Next it can pass through a differential (mark) encoder, which may be switched on or off. It is then coded by a rate-1/2 convolutional encoder. Last, each code symbol can be split into two half-symbols of opposite level, which may also be switched on or off.

One data bit therefore becomes two channel symbols, or four when the split-phase step is on. The output gives one symbol per clock. The source side uses a valid/ready handshake. Ready stays low while the symbols of the previous bit are still leaving. Ready rises again when only the last of them remains, so that a steady source produces a symbol stream with no gaps.

The configuration inputs are sampled at the moment a bit is accepted. A bit already in flight keeps the modes it was accepted with.

Top module: `tlm_bit_encoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A bit accepted with `in_sof` high restarts the whitening sequence at its first element. The sequence a[n] has a[0..7] all ones and follows a[n+8] = a[n+7] ^ a[n+5] ^ a[n+3] ^ a[n] (polynomial x^8+x^7+x^5+x^3+1).
- R3: The whitened bit is the data bit XOR a[n], where n counts the bits accepted since the last frame start. The sequence advances by exactly one element per accepted bit.
- R4: When `cfg_nrzm_en` is 1, the differential encoder's level starts at 0 after reset, toggles on a whitened 1 and holds on a whitened 0, and the level is what passes on. When `cfg_nrzm_en` is 0, the whitened bit passes unchanged and the level is held.
- R5: The convolutional encoder has constraint length 7 and a zero history after reset. With d0 as the current bit and dk as the bit k accepts earlier, c1 = d0^d1^d2^d3^d6 (171 octal) and c2 = NOT(d0^d2^d3^d5^d6) (133 octal, inverted).
- R6: With split-phase off, each accepted bit yields two symbols on consecutive cycles, c1 first and then c2.
- R7: With `cfg_split_en` at 1, each code symbol s goes out as s followed by NOT s. The four symbols per bit are c1, ~c1, c2, ~c2.
- R8: `in_ready` is low while more than one symbol of the previous bit is still to leave. For a source that is always valid, accepts are spaced exactly 2 cycles apart (4 with split-phase on), and `out_valid` has no gap.
- R9: Both configuration bits are sampled when a bit is accepted. Changing them while that bit's symbols are leaving does not change that bit's symbols.
- R10: The first symbol of an accepted bit appears on `out_sym` with `out_valid` high in the cycle after the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_nrzm_en | input | 1 | Enables the differential mark encoder |
| cfg_split_en | input | 1 | Enables split-phase symbol doubling |
| in_valid | input | 1 | Source offers a data bit |
| in_ready | output | 1 | Block can take a data bit this cycle |
| in_bit | input | 1 | Data bit |
| in_sof | input | 1 | Marks the first bit of a frame |
| out_valid | output | 1 | `out_sym` carries a channel symbol |
| out_sym | output | 1 | Channel symbol |

## Verification
Every stage holds state across bits: the whitening register, the mark level and the six-bit code history. A wrong value in any of them corrupts the symbols of the very next accepted bit, so a scoreboard that compares every symbol in order exposes it within two to four cycles. The code history and the mark level then keep the error alive in later symbols, while a frame start clears the whitening error. A wrong symbol count or a wrong ready timing shows up at once, either as a gap in `out_valid`, as a leftover or missing symbol in the queue, or as a spacing between accepts other than 2 or 4 cycles.

// File: rtl/tlm_enc_pkg.sv
package tlm_enc_pkg;

    localparam int          WHITEN_W    = 8;
    localparam logic [7:0]  WHITEN_SEED = 8'hFF;
    localparam int          CODE_K      = 7;
    localparam logic [6:0]  CODE_G1     = 7'o171;
    localparam logic [6:0]  CODE_G2     = 7'o133;
    localparam int          SYMS_PLAIN  = 2;
    localparam int          SYMS_MAX    = 4;
    localparam int          SYM_CNT_W   = $clog2(SYMS_MAX + 1);

    typedef struct packed {
        logic nrzm_en;
        logic split_en;
    } enc_cfg_t;

    typedef struct packed {
        logic c2;
        logic c1;
    } code_pair_t;

    // Fibonacci step: state[7] is the oldest element and the output.
    function automatic logic [WHITEN_W-1:0] whiten_step(input logic [WHITEN_W-1:0] s);
        logic fb;
        fb = s[7] ^ s[4] ^ s[2] ^ s[0];
        return {s[WHITEN_W-2:0], fb};
    endfunction

    function automatic logic tap_parity(input logic [CODE_K-1:0] win,
                                        input logic [CODE_K-1:0] gen);
        return ^(win & gen);
    endfunction

endpackage

// File: rtl/tlm_whitener.sv
module tlm_whitener
    import tlm_enc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic sof,
    input  logic din,
    output logic dout
);
    logic [WHITEN_W-1:0] state_q;
    logic [WHITEN_W-1:0] cur;

    assign cur  = sof ? WHITEN_SEED : state_q;
    assign dout = din ^ cur[WHITEN_W-1];

    always_ff @(posedge clk) begin
        if (rst)       state_q <= WHITEN_SEED;
        else if (step) state_q <= whiten_step(cur);
    end

    // R2: a frame start reloads the seed, so one step later the state is FE
    a_r2_reseed_on_sof: assert property (@(posedge clk) disable iff (rst)
        (step && sof) |=> (state_q == 8'hFE));

    // R3: the sequence holds still when no bit is accepted
    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(state_q));
endmodule

// File: rtl/tlm_nrzm.sv
module tlm_nrzm (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic en,
    input  logic din,
    output logic dout
);
    logic level_q;
    logic next_level;

    assign next_level = level_q ^ din;
    assign dout       = en ? next_level : din;

    always_ff @(posedge clk) begin
        if (rst)             level_q <= 1'b0;
        else if (step && en) level_q <= next_level;
    end

    // R4: a zero holds the level
    a_r4_hold_on_zero: assert property (@(posedge clk) disable iff (rst)
        (step && en && !din) |=> $stable(level_q));
    // R4: bypass keeps the level untouched
    a_r4_bypass_holds: assert property (@(posedge clk) disable iff (rst)
        (step && !en) |=> $stable(level_q));
endmodule

// File: rtl/tlm_conv_coder.sv
module tlm_conv_coder
    import tlm_enc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       step,
    input  logic       din,
    output code_pair_t pair
);
    // hist_q[CODE_K-2] is the most recent earlier bit
    logic [CODE_K-2:0] hist_q;
    logic [CODE_K-1:0] window;

    assign window  = {din, hist_q};
    assign pair.c1 = tap_parity(window, CODE_G1);
    assign pair.c2 = ~tap_parity(window, CODE_G2);

    always_ff @(posedge clk) begin
        if (rst)       hist_q <= '0;
        else if (step) hist_q <= window[CODE_K-1:1];
    end

    // R5: history shifts in the accepted bit
    a_r5_history_shift: assert property (@(posedge clk) disable iff (rst)
        step |=> (hist_q[CODE_K-2] == $past(din)));
endmodule

// File: rtl/tlm_symbol_ser.sv
module tlm_symbol_ser
    import tlm_enc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       split,
    input  code_pair_t pair,
    output logic       ready,
    output logic       out_valid,
    output logic       out_sym
);
    logic [SYMS_MAX-1:0]  sym_q;
    logic [SYM_CNT_W-1:0] cnt_q;
    logic                 split_q;
    logic [SYMS_MAX-1:0]  split_vec;
    logic [SYMS_MAX-1:0]  plain_vec;
    logic [1:0]           pair_bits;

    assign pair_bits = {pair.c2, pair.c1};

    // each code symbol becomes the symbol then its complement
    for (genvar i = 0; i < SYMS_PLAIN; i++) begin : g_split
        assign split_vec[2*i]   = pair_bits[i];
        assign split_vec[2*i+1] = ~pair_bits[i];
    end
    assign plain_vec = {{(SYMS_MAX-SYMS_PLAIN){1'b0}}, pair_bits};

    assign ready     = (cnt_q <= SYM_CNT_W'(1));
    assign out_valid = (cnt_q != '0);
    assign out_sym   = sym_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_q   <= '0;
            cnt_q   <= '0;
            split_q <= 1'b0;
        end else if (load) begin
            sym_q   <= split ? split_vec : plain_vec;
            cnt_q   <= split ? SYM_CNT_W'(SYMS_MAX) : SYM_CNT_W'(SYMS_PLAIN);
            split_q <= split;
        end else if (cnt_q != '0) begin
            sym_q <= {1'b0, sym_q[SYMS_MAX-1:1]};
            cnt_q <= cnt_q - SYM_CNT_W'(1);
        end
    end

    // R7: second half of each split pair is the complement of the first
    a_r7_split_complement: assert property (@(posedge clk) disable iff (rst)
        (out_valid && split_q && cnt_q[0]) |-> (out_sym != $past(out_sym)));
    // R8: symbol count per bit follows the mode
    a_r8_count_split: assert property (@(posedge clk) disable iff (rst)
        (load && split) |=> (cnt_q == SYM_CNT_W'(SYMS_MAX)));
    a_r8_count_plain: assert property (@(posedge clk) disable iff (rst)
        (load && !split) |=> (cnt_q == SYM_CNT_W'(SYMS_PLAIN)));
endmodule

// File: rtl/tlm_bit_encoder.sv
module tlm_bit_encoder
    import tlm_enc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_nrzm_en,
    input  logic cfg_split_en,
    input  logic in_valid,
    output logic in_ready,
    input  logic in_bit,
    input  logic in_sof,
    output logic out_valid,
    output logic out_sym
);
    enc_cfg_t   cfg;
    logic       accept;
    logic       white_bit;
    logic       diff_bit;
    code_pair_t pair;

    assign cfg.nrzm_en  = cfg_nrzm_en;
    assign cfg.split_en = cfg_split_en;
    assign accept       = in_valid && in_ready;

    tlm_whitener u_whiten (
        .clk  (clk),
        .rst  (rst),
        .step (accept),
        .sof  (in_sof),
        .din  (in_bit),
        .dout (white_bit)
    );

    tlm_nrzm u_nrzm (
        .clk  (clk),
        .rst  (rst),
        .step (accept),
        .en   (cfg.nrzm_en),
        .din  (white_bit),
        .dout (diff_bit)
    );

    tlm_conv_coder u_conv (
        .clk  (clk),
        .rst  (rst),
        .step (accept),
        .din  (diff_bit),
        .pair (pair)
    );

    tlm_symbol_ser u_ser (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .split     (cfg.split_en),
        .pair      (pair),
        .ready     (in_ready),
        .out_valid (out_valid),
        .out_sym   (out_sym)
    );

    // R10: an accepted bit shows a symbol in the next cycle
    a_r10_symbol_next_cycle: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid);
    // R8: ready never drops while the output is idle
    a_r8_ready_when_idle: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);
endmodule

// File: tb/tb_tlm_bit_encoder.sv
module tb_tlm_bit_encoder;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_nrzm_en = 1'b0;
    logic cfg_split_en = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic in_bit = 1'b0;
    logic in_sof = 1'b0;
    logic out_valid;
    logic out_sym;

    always #4 clk = ~clk;

    tlm_bit_encoder dut (
        .clk          (clk),
        .rst          (rst),
        .cfg_nrzm_en  (cfg_nrzm_en),
        .cfg_split_en (cfg_split_en),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_bit       (in_bit),
        .in_sof       (in_sof),
        .out_valid    (out_valid),
        .out_sym      (out_sym)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    logic rseq [0:1023];
    int   ridx = 0;
    logic lvl  = 1'b0;
    logic [5:0] hist = '0;   // hist[0] = one accept ago
    logic exp_q [$];
    string tag_q [$];
    int   last_acc = 0;
    int   last_n   = 0;

    always @(negedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected symbol", 1, 0);
                end else begin
                    logic e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_sym == e, t, int'(out_sym), int'(e));
                end
            end else if (exp_q.size() != 0) begin
                check(1'b0, "R8 gap in out_valid", 0, 1);
            end
        end
    end

    task automatic send_bit(input logic b, input logic sof, input bit b2b, input bit flip);
        logic r, d, c1, c2;
        int n;
        in_valid = 1'b1;
        in_bit   = b;
        in_sof   = sof;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        // model from the requirements (R2, R3, R4, R5)
        if (sof) ridx = 0;
        r = b ^ rseq[ridx];
        ridx = ridx + 1;
        if (cfg_nrzm_en) begin
            d = lvl ^ r;
            lvl = d;
        end else begin
            d = r;
        end
        c1 = d ^ hist[0] ^ hist[1] ^ hist[2] ^ hist[5];
        c2 = ~(d ^ hist[1] ^ hist[2] ^ hist[4] ^ hist[5]);
        hist = {hist[4:0], d};
        if (cfg_split_en) begin
            exp_q.push_back(c1);  tag_q.push_back("R7 split c1");
            exp_q.push_back(~c1); tag_q.push_back("R7 split ~c1");
            exp_q.push_back(c2);  tag_q.push_back("R7 split c2");
            exp_q.push_back(~c2); tag_q.push_back("R7 split ~c2");
            n = 4;
        end else begin
            exp_q.push_back(c1); tag_q.push_back("R5 R6 c1");
            exp_q.push_back(c2); tag_q.push_back("R5 R6 c2");
            n = 2;
        end
        if (b2b) check((cyc - last_acc) == last_n, "R8 accept spacing", cyc - last_acc, last_n);
        last_acc = cyc;
        last_n   = n;
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        // R9: change the mode while this bit is still leaving
        if (flip) begin
            cfg_split_en = ~cfg_split_en;
            cfg_nrzm_en  = ~cfg_nrzm_en;
        end
    endtask

    task automatic send_frame(input int nbits, input int seed);
        logic [31:0] x;
        x = 32'(seed);
        for (int i = 0; i < nbits; i++) begin
            x = x * 32'd1103515245 + 32'd12345;
            send_bit(x[16], i == 0, i != 0, 1'b0);
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // watchdog
    always @(negedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) rseq[i] = 1'b1;
        for (int i = 0; i + 8 < 1024; i++)
            rseq[i+8] = rseq[i+7] ^ rseq[i+5] ^ rseq[i+3] ^ rseq[i];

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

        // R10: first symbol the cycle after accept
        in_valid = 1'b1; in_bit = 1'b0; in_sof = 1'b1;
        @(posedge clk);
        ridx = 1; hist = 6'b000001;  // whitened bit 1, nrzm off
        exp_q.push_back(1'b1); tag_q.push_back("R10 first c1");
        exp_q.push_back(1'b0); tag_q.push_back("R10 first c2");
        @(negedge clk);
        check(out_valid == 1'b1, "R10 out_valid after accept", int'(out_valid), 1);
        in_valid = 1'b0; in_sof = 1'b0;
        drain();

        // plain mode, several frames (R2 reseed, R3)
        send_frame(40, 7);
        send_frame(25, 99);
        drain();

        // differential encoding on (R4)
        cfg_nrzm_en = 1'b1;
        send_frame(60, 3);
        drain();

        // split-phase (R7) with and without differential
        cfg_split_en = 1'b1;
        send_frame(30, 11);
        cfg_nrzm_en = 1'b0;
        send_frame(30, 12);
        drain();

        // all-ones and all-zeros data patterns
        cfg_split_en = 1'b0;
        for (int i = 0; i < 20; i++) send_bit(1'b1, i == 0, i != 0, 1'b0);
        for (int i = 0; i < 20; i++) send_bit(1'b0, i == 0, i != 0, 1'b0);
        drain();

        // R9: mode flips while a bit's symbols are in flight
        for (int i = 0; i < 12; i++) send_bit(i[0], i == 0, 1'b0, 1'b1);
        drain();

        // bits separated by idle cycles
        cfg_nrzm_en = 1'b1; cfg_split_en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            send_bit(i[1], i == 0, 1'b0, 1'b0);
            repeat (i % 4 + 1) @(negedge clk);
        end
        drain();

        // long frame past the sequence period
        cfg_split_en = 1'b0;
        send_frame(300, 5);
        drain();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule